// File: doc/BRIEF.md
# Double-Width Sequential Integer Divider

This block divides a dividend twice as wide as its divisor. The dividend arrives as two halves of N bits each, upper and lower, and the divisor is N bits. The result is an N-bit quotient and an N-bit remainder. A mode input selects two's-complement or plain binary interpretation of all operands. The quotient is truncated toward zero, and in signed mode a nonzero remainder carries the sign of the dividend.

The divider works over several cycles with a start/busy/done handshake. On a start pulse it latches the operands and develops one quotient bit per clock, using restoring shift-and-subtract on magnitudes. It applies the signs in one final cycle. A divisor of zero, or a quotient that cannot be held in N bits, does not produce a result. In that case the block pulses done together with a divide-error flag and leaves the previous quotient and remainder on the outputs.

Top module: `dbl_divider`

## Requirements
- R1: After reset, busy, done and divError are low, and quotient and remainder are zero.
- R2: With signedMode = 0, the dividend {dividendHi, dividendLo} and the divisor are read as unsigned. A non-error result gives quotient = floor(dividend / divisor) and remainder = dividend - quotient*divisor.
- R3: With signedMode = 1, all operands are two's complement. The quotient is truncated toward zero, and the remainder equals dividend - quotient*divisor, so it is zero or has the dividend's sign.
- R4: A zero divisor makes done pulse with divError = 1, and quotient and remainder keep the values they held before.
- R5: In unsigned mode, a quotient of 2^N or more (dividendHi >= divisor) is reported as a divide error, with the outputs unchanged.
- R6: In signed mode, a true quotient outside -2^(N-1) to 2^(N-1)-1 is reported as a divide error, with the outputs unchanged. A quotient of exactly -2^(N-1) is a valid result.
- R7: Start is sampled on a rising edge while the block is idle. Done rises N+2 edges later for a division that completes. It rises 2 edges later for a zero divisor or for unsigned-range overflow detected at load.
- R8: Done is high for exactly one cycle. Busy is high from the edge that accepts start until done rises, and busy is low while done is high.
- R9: A start pulse while busy is high has no effect: the running result is not changed and no extra done is produced.
- R10: signedMode = 1 selects signed operation and 0 selects unsigned. The same operand bits can therefore give different outcomes in the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled when idle |
| signedMode | input | 1 | 1 = two's complement, 0 = unsigned |
| dividendHi | input | N | Upper half of the dividend |
| dividendLo | input | N | Lower half of the dividend |
| divisor | input | N | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| divError | output | 1 | Valid with done: zero divisor or quotient out of range |
| quotient | output | N | Quotient of the last successful division |
| remainder | output | N | Remainder of the last successful division |

## Verification
Some behaviours are checked by assertions on every cycle:
- done lasts a single cycle and never coincides with busy;
- the partial remainder is below the divisor magnitude when the sign fix-up cycle begins;
- an error completion leaves both result outputs untouched;
- a signed, nonzero remainder matches the dividend's sign.

Other behaviours can only be shown by the bench's scenarios:
- the arithmetic values;
- the exact boundary where signed overflow starts (-2^(N-1) accepted, +2^(N-1) rejected);
- the latency counts;
- that a start pulse issued mid-run is ignored.

// File: rtl/dbl_div_pkg.sv
package dbl_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } divState_t;

  typedef struct packed {
    logic load;    // latch operands and magnitudes
    logic step;    // one restoring shift-subtract iteration
    logic finish;  // apply signs, range check, publish
  } divStrobes_t;

endpackage

// File: rtl/dbl_div_ctrl.sv
module dbl_div_ctrl
  import dbl_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        preErr,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

  divState_t      state;
  logic [CW-1:0]  stepCnt;

  always_comb begin
    strobes        = '0;
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FINISH);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            stepCnt <= '0;
            state   <= preErr ? ST_FINISH : ST_RUN;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion pulse lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: block reports idle while done is shown
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: a run in progress is never restarted by a new load
  p_no_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> (state != ST_IDLE) || $past(stepCnt) == LAST_STEP);

endmodule

// File: rtl/dbl_div_dp.sv
module dbl_div_dp
  import dbl_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  divStrobes_t strobes,
  input  logic        signedMode,
  input  logic [N-1:0] dividendHi,
  input  logic [N-1:0] dividendLo,
  input  logic [N-1:0] divisor,
  output logic        preErr,
  output logic        divError,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);

  localparam int W2 = 2 * N;
  localparam logic [N-1:0] HALF_RANGE = {1'b1, {(N-1){1'b0}}};

  // operand magnitudes, formed combinationally from the inputs
  logic [W2-1:0] fullDd, ddMag;
  logic [N-1:0]  dvMag;
  logic          ddNeg, dvNeg;

  assign fullDd = {dividendHi, dividendLo};
  assign ddNeg  = signedMode & dividendHi[N-1];
  assign dvNeg  = signedMode & divisor[N-1];
  assign ddMag  = ddNeg ? (~fullDd + 1'b1) : fullDd;
  assign dvMag  = dvNeg ? (~divisor + 1'b1) : divisor;
  assign preErr = (dvMag == '0) || (ddMag[W2-1:N] >= dvMag);

  // working registers
  logic [N-1:0] remReg, quoReg, divReg;
  logic         negQ, negR, signedLat, errLat;

  logic [N:0]   shifted, trial;
  logic         fits;

  assign shifted = {remReg, quoReg[N-1]};
  assign fits    = shifted >= {1'b0, divReg};
  assign trial   = shifted - {1'b0, divReg};

  // final fix-up
  logic [N-1:0] qFixed, rFixed;
  logic         rangeErr, finalErr;

  assign qFixed   = negQ ? (~quoReg + 1'b1) : quoReg;
  assign rFixed   = negR ? (~remReg + 1'b1) : remReg;
  assign rangeErr = signedLat && (negQ ? (quoReg > HALF_RANGE) : quoReg[N-1]);
  assign finalErr = errLat || rangeErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg    <= '0;
      quoReg    <= '0;
      divReg    <= '0;
      negQ      <= 1'b0;
      negR      <= 1'b0;
      signedLat <= 1'b0;
      errLat    <= 1'b0;
      divError  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      divError <= 1'b0;
      if (strobes.load) begin
        remReg    <= ddMag[W2-1:N];
        quoReg    <= ddMag[N-1:0];
        divReg    <= dvMag;
        negQ      <= ddNeg ^ dvNeg;
        negR      <= ddNeg;
        signedLat <= signedMode;
        errLat    <= preErr;
      end
      if (strobes.step) begin
        remReg <= fits ? trial[N-1:0] : shifted[N-1:0];
        quoReg <= {quoReg[N-2:0], fits};
      end
      if (strobes.finish) begin
        divError <= finalErr;
        if (!finalErr) begin
          quotient  <= qFixed;
          remainder <= rFixed;
        end
      end
    end
  end

  // R2: restoring iterations leave a partial remainder below the divisor
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !errLat) |-> (remReg < divReg));

  // R4: an error completion does not disturb the published result
  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    divError |-> ($stable(quotient) && $stable(remainder)));

  // R3: signed nonzero remainder follows the dividend sign
  p_rem_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.finish) && !divError && signedLat && remainder != '0)
      |-> (remainder[N-1] == negR));

endmodule

// File: rtl/dbl_divider.sv
module dbl_divider
  import dbl_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         signedMode,
  input  logic [N-1:0] dividendHi,
  input  logic [N-1:0] dividendLo,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         divError,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);

  divStrobes_t strobes;
  logic        preErr;

  dbl_div_ctrl #(.N(N)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .preErr  (preErr),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  dbl_div_dp #(.N(N)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .signedMode (signedMode),
    .dividendHi (dividendHi),
    .dividendLo (dividendLo),
    .divisor    (divisor),
    .preErr     (preErr),
    .divError   (divError),
    .quotient   (quotient),
    .remainder  (remainder)
  );

endmodule

// File: tb/sim_dbl_divider.sv
`timescale 1ns/1ps
module sim_dbl_divider;

  localparam int N = 8;

  typedef struct {
    logic [N-1:0] q;
    logic [N-1:0] r;
    logic         err;
    int           lat;
    int           startCyc;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [N-1:0] dividendHi = '0, dividendLo = '0, divisor = '0;
  logic busy, done, divError;
  logic [N-1:0] quotient, remainder;

  always #5 clk = ~clk;

  dbl_divider #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .busy(busy), .done(done), .divError(divError),
    .quotient(quotient), .remainder(remainder)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int doneCount = 0;
  expItem_t sb[$];
  logic [N-1:0] lastQ = '0, lastR = '0;
  logic prevDone = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && done) check(1'b0, "R8", "done longer than one cycle", 1, 0);
      if (done) begin
        doneCount++;
        check(!busy, "R8", "busy during done", busy, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = sb.pop_front();
          check(divError == e.err, e.tag, "divError", divError, e.err);
          check(quotient == e.q, e.tag, "quotient", quotient, e.q);
          check(remainder == e.r, e.tag, "remainder", remainder, e.r);
          check(cyc - e.startCyc == e.lat, "R7", "latency", cyc - e.startCyc, e.lat);
        end
      end
      prevDone <= done;
    end
  end

  // driver: computes the expected outcome, then issues the division
  task automatic runOp(input logic [N-1:0] hi, input logic [N-1:0] lo,
                       input logic [N-1:0] dv, input logic sg,
                       input string tag, input bit poke);
    expItem_t e;
    longint dd, dvs, q, r;
    bit err, early;
    int prevCount;
    if (sg) begin
      dd  = longint'($signed({hi, lo}));
      dvs = longint'($signed(dv));
    end else begin
      dd  = longint'({hi, lo});
      dvs = longint'(dv);
    end
    err = 1'b0; early = 1'b0; q = 0; r = 0;
    if (dvs == 0) begin
      err = 1'b1; early = 1'b1;
    end else begin
      q = dd / dvs;
      r = dd - q * dvs;
      if (sg) begin
        if (q > (64'sd1 <<< (N-1)) - 1 || q < -(64'sd1 <<< (N-1))) err = 1'b1;
        if (q >= (64'sd1 <<< N) || q <= -(64'sd1 <<< N)) early = 1'b1;
      end else if (q >= (64'sd1 <<< N)) begin
        err = 1'b1; early = 1'b1;
      end
    end
    e.err = err;
    e.q   = err ? lastQ : q[N-1:0];
    e.r   = err ? lastR : r[N-1:0];
    e.lat = early ? 2 : N + 2;
    e.tag = tag;
    if (!err) begin lastQ = q[N-1:0]; lastR = r[N-1:0]; end
    prevCount = doneCount;
    @(negedge clk);
    dividendHi = hi; dividendLo = lo; divisor = dv; signedMode = sg;
    e.startCyc = cyc;
    sb.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R9", "busy mid-run", busy, 1);
      dividendHi = 8'h00; dividendLo = 8'h09; divisor = 8'h03; signedMode = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCount == prevCount) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finishRun();
      end
    join_none
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1", "busy", busy, 0);
    check(done == 0, "R1", "done", done, 0);
    check(divError == 0, "R1", "divError", divError, 0);
    check(quotient == 0, "R1", "quotient", quotient, 0);
    check(remainder == 0, "R1", "remainder", remainder, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOp(8'h03, 8'hE8, 8'd7,  1'b0, "R2", 0);   // 1000/7
    runOp(8'hFE, 8'hFF, 8'hFF, 1'b0, "R2", 0);   // max fitting quotient 255
    runOp(8'h00, 8'h00, 8'd5,  1'b0, "R2", 0);   // zero dividend
    runOp(8'h05, 8'h00, 8'd5,  1'b0, "R5", 0);   // hi == divisor
    runOp(8'h12, 8'h34, 8'h00, 1'b0, "R4", 0);   // zero divisor unsigned
    runOp(8'hFF, 8'h9C, 8'd7,  1'b1, "R3", 0);   // -100/7
    runOp(8'h00, 8'h64, 8'hF9, 1'b1, "R3", 0);   // 100/-7
    runOp(8'hFF, 8'h9C, 8'hF9, 1'b1, "R3", 0);   // -100/-7
    runOp(8'hFF, 8'h80, 8'd1,  1'b1, "R6", 0);   // -128/1 valid edge
    runOp(8'h00, 8'h80, 8'd1,  1'b1, "R6", 0);   // 128/1 overflow
    runOp(8'hC0, 8'h00, 8'h80, 1'b1, "R6", 0);   // -16384/-128 = 128
    runOp(8'h80, 8'h00, 8'hFF, 1'b1, "R6", 0);   // -32768/-1
    runOp(8'h00, 8'h05, 8'h00, 1'b1, "R4", 0);   // zero divisor signed
    runOp(8'h7F, 8'hFF, 8'h80, 1'b0, "R10", 0);  // unsigned: 255 r 127
    runOp(8'h7F, 8'hFF, 8'h80, 1'b1, "R10", 0);  // signed: -255 -> error
    runOp(8'h01, 8'h2C, 8'd9,  1'b0, "R9", 1);   // 300/9 with a mid-run start
    repeat (N + 6) @(negedge clk);
    check(sb.size() == 0, "R9", "pending items", sb.size(), 0);
    finishRun();
  end

endmodule